// File: doc/BRIEF.md
# Listener Byte Handshake Engine for a Parallel Instrument Bus

This block is the accepting side of the three-wire byte handshake on an IEEE-488 style bus. A local controller asks for one byte with a request pulse. The engine then lets NRFD float high while it keeps NDAC low, and waits for the talker to pull DAV low. Once DAV is low, it pulls NRFD low and captures the data lines together with the ATN and EOI levels. It then releases NDAC and waits for DAV to return high. At that point it pulls NDAC low again and reports the byte with a one-cycle valid pulse. Between bytes, NRFD stays low, so the talker cannot start a new transfer until the controller asks for one.

Every bus line is active low. The bus outputs are pull-low enables that drive external open-drain buffers. Any talker must be held off within a few hundred nanoseconds of ATN being asserted, and no clocked logic can respond that fast. For this reason, an armed echo path copies a low ATN straight onto the NRFD pull-down without using the clock. The engine disarms this path as soon as it takes control of NRFD for a byte. The echo is armed again by reset, by an interface clear (IFC), or by an explicit re-arm from the controller. DAV, ATN and IFC pass through two-flop synchronizers before the state machine uses them. Decisions about addressing belong to the controller.

Top module: `gpib_listen_hs`

## Requirements
- R1: After reset, `nrfd_pull` is 0 while `atn_n` is high, `ndac_pull` is 0, `byte_valid` is 0, and the ATN echo is armed.
- R2: While the echo is armed, `atn_n` low sets `nrfd_pull` to 1 combinationally, with no clock edge in between. `atn_n` high removes it again.
- R3: Suppose a `req` pulse arrives while the engine is idle or holding. In the next cycle `nrfd_pull` is 0 and `ndac_pull` is 1, and the echo is disarmed, so a low ATN no longer pulls NRFD.
- R4: After DAV low has passed the synchronizer, the engine pulls NRFD low and captures the byte. It then releases NDAC while it keeps NRFD pulled, so NDAC is never released during a handshake unless NRFD is pulled.
- R5: After DAV returns high, NDAC is pulled again and NRFD stays pulled. `byte_valid` pulses for exactly one cycle. The word layout is: bit 9 = EOI asserted, bit 8 = ATN asserted, bits 7:0 = bitwise inverse of `dio_n`.
- R6: Bit 8 of the word is 1 when ATN was low at the moment of acceptance (a command byte) and 0 when ATN was high (a data byte).
- R7: A `req` pulse during a handshake that is still in progress is ignored. After completion the engine holds, with NRFD pulled.
- R8: IFC low, once synchronized, aborts any handshake. The engine returns to idle with both lines released, re-arms the echo and produces no `byte_valid`. If IFC and DAV change in the same cycle, IFC wins.
- R9: An `echo_arm` pulse while holding returns the engine to idle. Both lines are released and the echo is armed again.
- R10: DAV activity with no `req` pending produces no `byte_valid` and does not pull NDAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request one byte (pulse) |
| echo_arm | input | 1 | Re-arm the ATN echo and go idle (pulse) |
| dio_n | input | 8 | Bus data lines, active low |
| dav_n | input | 1 | Data valid, active low |
| atn_n | input | 1 | Attention, active low |
| eoi_n | input | 1 | End marker, active low |
| ifc_n | input | 1 | Interface clear, active low |
| nrfd_pull | output | 1 | Pull NRFD low |
| ndac_pull | output | 1 | Pull NDAC low |
| byte_valid | output | 1 | One-cycle pulse when a byte completes |
| byte_word | output | 10 | {eoi, atn, data} of the last byte |

## Verification
An interface clear and the arrival of a falling DAV can reach the state machine in the same cycle, because both travel through synchronizers of equal depth. The bench provokes this by changing `ifc_n` and `dav_n` on the same clock phase while the engine is waiting for DAV. It judges the outcome at the ports. There must be no `byte_valid` pulse and NDAC must be released. An ATN assertion must then pull NRFD through the echo, which proves that the echo was re-armed rather than left disarmed by a completed handshake.

// File: rtl/gpib_listen_hs.sv
module gpib_listen_hs #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              echo_arm,
  input  logic [DATA_W-1:0] dio_n,
  input  logic              dav_n,
  input  logic              atn_n,
  input  logic              eoi_n,
  input  logic              ifc_n,
  output logic              nrfd_pull,
  output logic              ndac_pull,
  output logic              byte_valid,
  output logic [DATA_W+1:0] byte_word
);

  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  typedef enum logic [2:0] {S_IDLE, S_READY, S_TAKE, S_DRAIN, S_HOLD} st_t;

  st_t           state;
  logic          echo_en;
  logic [SW-1:0] dav_sr, atn_sr, ifc_sr;
  logic          dav_s, atn_s, ifc_s;
  logic          nrfd_drive, ndac_drive;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dav_sr <= '1;
      atn_sr <= '1;
      ifc_sr <= '1;
    end else begin
      dav_sr <= {dav_sr[SW-2:0], dav_n};
      atn_sr <= {atn_sr[SW-2:0], atn_n};
      ifc_sr <= {ifc_sr[SW-2:0], ifc_n};
    end

  assign dav_s = dav_sr[SW-1];
  assign atn_s = atn_sr[SW-1];
  assign ifc_s = ifc_sr[SW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= S_IDLE;
      echo_en    <= 1'b1;
      byte_valid <= 1'b0;
      byte_word  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (!ifc_s) begin
        state   <= S_IDLE;
        echo_en <= 1'b1;
      end else begin
        case (state)
          S_IDLE, S_HOLD:
            if (req) begin
              state   <= S_READY;
              echo_en <= 1'b0;
            end else if (echo_arm) begin
              state   <= S_IDLE;
              echo_en <= 1'b1;
            end
          S_READY:
            if (!dav_s) begin
              byte_word <= {~eoi_n, ~atn_s, ~dio_n};
              state     <= S_TAKE;
            end
          S_TAKE:
            state <= S_DRAIN;
          S_DRAIN:
            if (dav_s) begin
              state      <= S_HOLD;
              byte_valid <= 1'b1;
            end
          default:
            state <= S_IDLE;
        endcase
      end
    end

  assign nrfd_drive = (state == S_TAKE) || (state == S_DRAIN) || (state == S_HOLD);
  assign ndac_drive = (state == S_READY) || (state == S_TAKE) || (state == S_HOLD);

  assign nrfd_pull = nrfd_drive | (echo_en & ~atn_n);
  assign ndac_pull = ndac_drive;

  assert_request_takes_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ifc_s && (state == S_IDLE || state == S_HOLD)) |=> (ndac_pull && !nrfd_pull));

  assert_ndac_release_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !ndac_pull) |-> nrfd_pull);

  assert_valid_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_valid_lines_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (nrfd_pull && ndac_pull));

  assert_clear_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ifc_s |=> (!ndac_pull && !byte_valid));

endmodule

// File: tb/tb_gpib_listen_hs.sv
module tb_gpib_listen_hs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, echo_arm = 1'b0;
  logic [7:0] dio_n = 8'hFF;
  logic       dav_n = 1'b1, atn_n = 1'b1, eoi_n = 1'b1, ifc_n = 1'b1;
  logic       nrfd_pull, ndac_pull, byte_valid;
  logic [9:0] byte_word;

  int total = 0, bad = 0, pulses = 0;
  logic [9:0] last_word = '0;

  always #10 clk = ~clk;

  gpib_listen_hs dut (
    .clk(clk), .rst_n(rst_n), .req(req), .echo_arm(echo_arm), .dio_n(dio_n),
    .dav_n(dav_n), .atn_n(atn_n), .eoi_n(eoi_n), .ifc_n(ifc_n),
    .nrfd_pull(nrfd_pull), .ndac_pull(ndac_pull),
    .byte_valid(byte_valid), .byte_word(byte_word)
  );

  always @(negedge clk)
    if (byte_valid) begin
      pulses    <= pulses + 1;
      last_word <= byte_word;
    end

  // {dio_n, atn_n, eoi_n, expected word}
  localparam logic [19:0] VEC [0:5] = '{
    {8'hDB, 1'b0, 1'b1, 10'h124},
    {8'hC0, 1'b0, 1'b1, 10'h13F},
    {8'hBE, 1'b1, 1'b1, 10'h041},
    {8'h00, 1'b1, 1'b0, 10'h2FF},
    {8'hFF, 1'b1, 1'b1, 10'h000},
    {8'h5A, 1'b0, 1'b0, 10'h3A5}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    req = 1'b1;
    tick(1);
    req = 1'b0;
  endtask

  task automatic run_byte(input logic [7:0] d, input logic a, input logic e, input logic [9:0] exp);
    int p0;
    p0 = pulses;
    atn_n = a; eoi_n = e; dio_n = d;
    tick(4);
    pulse_req();
    chk(!nrfd_pull && ndac_pull, "R3 ready lines", {nrfd_pull, ndac_pull}, 2'b01);
    dav_n = 1'b0;
    tick(5);
    chk(nrfd_pull && !ndac_pull, "R4 accepted lines", {nrfd_pull, ndac_pull}, 2'b10);
    dav_n = 1'b1;
    tick(5);
    chk(nrfd_pull && ndac_pull && pulses == p0 + 1, "R5 completion", {nrfd_pull, ndac_pull, 8'(pulses - p0)}, {2'b11, 8'd1});
    chk(last_word == exp, "R5 R6 word", last_word, exp);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    tick(2);
    chk(!nrfd_pull && !ndac_pull && !byte_valid, "R1 reset", {nrfd_pull, ndac_pull, byte_valid}, 3'b000);
    rst_n = 1'b1;
    tick(2);
    chk(!nrfd_pull && !ndac_pull, "R1 idle lines", {nrfd_pull, ndac_pull}, 2'b00);

    atn_n = 1'b0; #2;
    chk(nrfd_pull, "R2 echo asserts", nrfd_pull, 1);
    atn_n = 1'b1; #2;
    chk(!nrfd_pull, "R2 echo releases", nrfd_pull, 0);

    p0 = pulses;
    dav_n = 1'b0; tick(5);
    chk(!ndac_pull, "R10 ndac idle", ndac_pull, 0);
    dav_n = 1'b1; tick(5);
    chk(pulses == p0, "R10 no pulse", pulses, p0);

    for (int i = 0; i < 6; i++)
      run_byte(VEC[i][19:12], VEC[i][11], VEC[i][10], VEC[i][9:0]);

    // R3: echo disarmed after request, ATN low leaves NRFD released
    atn_n = 1'b0; tick(4);
    pulse_req();
    chk(!nrfd_pull, "R3 echo disarmed", nrfd_pull, 0);
    atn_n = 1'b1;
    dav_n = 1'b0; dio_n = 8'hF0; tick(5);
    req = 1'b1; tick(1); req = 1'b0;
    p0 = pulses;
    dav_n = 1'b1; tick(5);
    chk(pulses == p0 + 1, "R7 one pulse", pulses - p0, 1);
    chk(nrfd_pull && ndac_pull, "R7 holding", {nrfd_pull, ndac_pull}, 2'b11);

    echo_arm = 1'b1; tick(1); echo_arm = 1'b0;
    chk(!nrfd_pull && !ndac_pull, "R9 released", {nrfd_pull, ndac_pull}, 2'b00);
    atn_n = 1'b0; #2;
    chk(nrfd_pull, "R9 echo armed", nrfd_pull, 1);
    atn_n = 1'b1; tick(4);

    pulse_req();
    p0 = pulses;
    ifc_n = 1'b0; dav_n = 1'b0; tick(5);
    chk(!ndac_pull && !nrfd_pull, "R8 abort lines", {nrfd_pull, ndac_pull}, 2'b00);
    atn_n = 1'b0; #2;
    chk(nrfd_pull, "R8 echo rearmed", nrfd_pull, 1);
    ifc_n = 1'b1; dav_n = 1'b1; atn_n = 1'b1; tick(5);
    chk(pulses == p0, "R8 no pulse", pulses - p0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule